// File: doc/BRIEF.md
# Two-Wide In-Order Completion Queue

This block is the retirement stage of an out-of-order core. Up to two instructions enter per cycle in program order. Each carries a rename-register tag, a destination kind and an architectural register index. Execution units later report results by rename tag. The entry holding that tag becomes finished, and the report may flag an exception with a 4-bit cause.

Each cycle the queue looks only at its two oldest entries. It retires them strictly in order and drives up to two commit writes. These carry the rename tag to read from, the architectural register index, and one write enable for the general, floating-point, count or link register file. When an instruction reaching retirement carries an exception, it is not committed. Every entry from it onward is cancelled and its rename tag is reported freed in that same cycle. A fetch redirect to the exception vector chosen by the cause is raised, and the queue is empty on the next cycle.

The reset is asserted asynchronously and released through a two-stage synchronizer inside the block.

Top module: `cmpl_queue`

## Requirements
- R1: After reset, and while reset is held, the queue is empty: no commit, no redirect, no freed tags, and a two-instruction dispatch is not stalled.
- R2: A dispatch is accepted only as a whole. The stall output rises when the number of requested instructions exceeds the free slots (queue depth, 6 by default, minus occupied entries, with retirements in the same cycle not counted). Then nothing is written. Stall is also high in every flush cycle.
- R3: A finish report marks the entry holding the reported rename tag as finished. A report whose tag matches no entry has no effect.
- R4: Only the two oldest entries can retire. Commit port 0 always carries the oldest entry, and port 1 the next one.
- R5: The second-oldest entry commits only in the same cycle as the oldest, and only when both are finished without exception. A finished second entry behind an unfinished oldest one waits.
- R6: A commit raises exactly one write enable, chosen by the destination kind given at dispatch: 0 general, 1 floating-point, 2 count, 3 link. It also carries the dispatched register index and rename tag.
- R7: A finished entry that carries an exception, at either of the two oldest positions, does not commit. The redirect is raised for one cycle with address VEC_BASE + cause * 2^VEC_SHIFT. An oldest entry finished cleanly ahead of it still commits in that cycle.
- R8: In the flush cycle the freed mask has bit i set for every valid entry at position i (0 = oldest) from the excepting entry onward, and the freed tag lanes show their tags. The queue is empty on the next cycle, and dispatch and finish inputs of the flush cycle are dropped.
- R9: An entry finished at one clock edge shows on the commit outputs right after that edge and leaves the queue at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_vld_i | input | 2 | Dispatch lane valid, lane 0 older |
| disp_tag_i | input | 2x4 | Rename tag per dispatch lane |
| disp_dst_i | input | 2x2 | Destination kind per lane (0 gen, 1 fp, 2 count, 3 link) |
| disp_areg_i | input | 2x5 | Architectural register index per lane |
| disp_stall_o | output | 1 | Dispatch refused this cycle |
| fin_vld_i | input | 2 | Finish report valid per port |
| fin_tag_i | input | 2x4 | Rename tag of the finished instruction |
| fin_exc_i | input | 2 | Finished instruction raised an exception |
| fin_cause_i | input | 2x4 | Exception cause code |
| cm_vld_o | output | 2 | Commit valid, lane 0 oldest |
| cm_tag_o | output | 2x4 | Rename tag to copy from |
| cm_areg_o | output | 2x5 | Architectural register to write |
| gpr_we_o | output | 2 | General register file write per lane |
| fpr_we_o | output | 2 | Floating-point register file write per lane |
| cnt_we_o | output | 2 | Count register write per lane |
| lnk_we_o | output | 2 | Link register write per lane |
| redir_vld_o | output | 1 | Fetch redirect to exception vector |
| redir_addr_o | output | 32 | Exception vector address |
| fl_free_o | output | 6 | Rename tags released by a flush, per position |
| fl_free_tag_o | output | 6x4 | Tag held at each position |

## Verification
A wrong internal state surfaces at the commit ports at the latest one cycle after it is written. Retire outputs are decoded straight from the two oldest registered entries. A lost finish mark therefore shows as a missing commit on the next cycle. A misplaced dispatch shows as commit tags out of program order, and a wrong count shows as a stall that comes early or late. A flush that leaves entries behind shows in the cycle right after the redirect, either as a stall or as stale commits.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // retirement and dispatch are two lanes wide by definition of the block
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    DST_GPR = 2'd0,
    DST_FPR = 2'd1,
    DST_CNT = 2'd2,
    DST_LNK = 2'd3
  } dst_e;

endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/rq_slots.sv
module rq_slots
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH   = 6,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned AREG_W  = 5,
  parameter int unsigned CAUSE_W = 4,
  parameter int unsigned NFIN    = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  flush_i,
  input  logic [1:0]                            ret_n_i,
  input  logic                                  acc_i,
  input  logic [LANES-1:0]                      disp_vld_i,
  input  logic [LANES-1:0][TAG_W-1:0]           disp_tag_i,
  input  logic [LANES-1:0][1:0]                 disp_dst_i,
  input  logic [LANES-1:0][AREG_W-1:0]          disp_areg_i,
  input  logic [NFIN-1:0]                       fin_vld_i,
  input  logic [NFIN-1:0][TAG_W-1:0]            fin_tag_i,
  input  logic [NFIN-1:0]                       fin_exc_i,
  input  logic [NFIN-1:0][CAUSE_W-1:0]          fin_cause_i,
  output logic [DEPTH-1:0]                      vld_o,
  output logic [DEPTH-1:0][TAG_W-1:0]           tag_o,
  output logic [LANES-1:0]                      bot_done_o,
  output logic [LANES-1:0]                      bot_exc_o,
  output logic [LANES-1:0][CAUSE_W-1:0]         bot_cause_o,
  output logic [LANES-1:0][1:0]                 bot_dst_o,
  output logic [LANES-1:0][AREG_W-1:0]          bot_areg_o,
  output logic [CNT_W-1:0]                      cnt_o
);

  localparam int unsigned EXT = DEPTH + 2;

  // registered state: status group is reset, payload group is not
  logic [DEPTH-1:0]               r_vld, r_done, r_exc;
  logic [DEPTH-1:0][CAUSE_W-1:0]  r_cause;
  logic [DEPTH-1:0][TAG_W-1:0]    r_tag;
  logic [DEPTH-1:0][1:0]          r_dst;
  logic [DEPTH-1:0][AREG_W-1:0]   r_areg;

  // state after this cycle's finish reports
  logic [DEPTH-1:0]               u_done, u_exc;
  logic [DEPTH-1:0][CAUSE_W-1:0]  u_cause;

  // padded copies so that a shift by up to two never indexes past the end
  logic [EXT-1:0]                 e_vld, e_done, e_exc;
  logic [EXT-1:0][CAUSE_W-1:0]    e_cause;
  logic [EXT-1:0][TAG_W-1:0]      e_tag;
  logic [EXT-1:0][1:0]            e_dst;
  logic [EXT-1:0][AREG_W-1:0]     e_areg;

  logic [DEPTH-1:0]               n_vld, n_done, n_exc;
  logic [DEPTH-1:0][CAUSE_W-1:0]  n_cause;
  logic [DEPTH-1:0][TAG_W-1:0]    n_tag;
  logic [DEPTH-1:0][1:0]          n_dst;
  logic [DEPTH-1:0][AREG_W-1:0]   n_areg;

  logic [CNT_W-1:0]               cnt, base, pos1;
  logic                           ld_en;

  // occupancy
  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CNT_W'(r_vld[i]);
    end
  end

  // finish reports matched against held rename tags
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      u_done[i]  = r_done[i];
      u_exc[i]   = r_exc[i];
      u_cause[i] = r_cause[i];
      for (int p = 0; p < NFIN; p++) begin
        if (fin_vld_i[p] && r_vld[i] && (fin_tag_i[p] == r_tag[i])) begin
          u_done[i] = 1'b1;
          if (fin_exc_i[p]) begin
            u_exc[i]   = 1'b1;
            u_cause[i] = fin_cause_i[p];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < EXT; i++) begin
      if (i < DEPTH) begin
        e_vld[i]   = r_vld[i];
        e_done[i]  = u_done[i];
        e_exc[i]   = u_exc[i];
        e_cause[i] = u_cause[i];
        e_tag[i]   = r_tag[i];
        e_dst[i]   = r_dst[i];
        e_areg[i]  = r_areg[i];
      end else begin
        e_vld[i]   = 1'b0;
        e_done[i]  = 1'b0;
        e_exc[i]   = 1'b0;
        e_cause[i] = '0;
        e_tag[i]   = '0;
        e_dst[i]   = '0;
        e_areg[i]  = '0;
      end
    end
  end

  // append positions: first free slot after the retiring entries leave
  assign base  = cnt - CNT_W'(ret_n_i);
  assign pos1  = base + CNT_W'(disp_vld_i[0]);
  assign ld_en = acc_i | (ret_n_i != 2'd0);

  // next state: shift down by the retire count, append, then flush
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_vld[i]   = 1'b0;
      n_done[i]  = 1'b0;
      n_exc[i]   = 1'b0;
      n_cause[i] = u_cause[i];
      n_tag[i]   = r_tag[i];
      n_dst[i]   = r_dst[i];
      n_areg[i]  = r_areg[i];
      for (int r = 0; r < 3; r++) begin
        if ((ret_n_i == 2'(r)) && e_vld[i + r]) begin
          n_vld[i]   = 1'b1;
          n_done[i]  = e_done[i + r];
          n_exc[i]   = e_exc[i + r];
          n_cause[i] = e_cause[i + r];
          n_tag[i]   = e_tag[i + r];
          n_dst[i]   = e_dst[i + r];
          n_areg[i]  = e_areg[i + r];
        end
      end
      if (acc_i && disp_vld_i[0] && (CNT_W'(i) == base)) begin
        n_vld[i]   = 1'b1;
        n_done[i]  = 1'b0;
        n_exc[i]   = 1'b0;
        n_cause[i] = '0;
        n_tag[i]   = disp_tag_i[0];
        n_dst[i]   = disp_dst_i[0];
        n_areg[i]  = disp_areg_i[0];
      end
      if (acc_i && disp_vld_i[1] && (CNT_W'(i) == pos1)) begin
        n_vld[i]   = 1'b1;
        n_done[i]  = 1'b0;
        n_exc[i]   = 1'b0;
        n_cause[i] = '0;
        n_tag[i]   = disp_tag_i[1];
        n_dst[i]   = disp_dst_i[1];
        n_areg[i]  = disp_areg_i[1];
      end
      if (flush_i) begin
        n_vld[i]  = 1'b0;
        n_done[i] = 1'b0;
        n_exc[i]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_vld   <= '0;
      r_done  <= '0;
      r_exc   <= '0;
      r_cause <= '0;
    end else begin
      r_vld   <= n_vld;
      r_done  <= n_done;
      r_exc   <= n_exc;
      r_cause <= n_cause;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_en) begin
      r_tag  <= n_tag;
      r_dst  <= n_dst;
      r_areg <= n_areg;
    end
  end

  assign vld_o = r_vld;
  assign tag_o = r_tag;
  assign cnt_o = cnt;

  for (genvar k = 0; k < LANES; k++) begin : g_bot
    assign bot_done_o[k]  = r_done[k];
    assign bot_exc_o[k]   = r_exc[k];
    assign bot_cause_o[k] = r_cause[k];
    assign bot_dst_o[k]   = r_dst[k];
    assign bot_areg_o[k]  = r_areg[k];
  end

endmodule

// File: rtl/rq_retire.sv
module rq_retire
  import rq_pkg::*;
#(
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned AREG_W    = 5,
  parameter int unsigned CAUSE_W   = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_0800,
  parameter int unsigned VEC_SHIFT = 8
) (
  input  logic [LANES-1:0]               vld_i,
  input  logic [LANES-1:0]               done_i,
  input  logic [LANES-1:0]               exc_i,
  input  logic [LANES-1:0][CAUSE_W-1:0]  cause_i,
  input  logic [LANES-1:0][TAG_W-1:0]    tag_i,
  input  logic [LANES-1:0][1:0]          dst_i,
  input  logic [LANES-1:0][AREG_W-1:0]   areg_i,
  output logic [LANES-1:0]               cm_vld_o,
  output logic [LANES-1:0][TAG_W-1:0]    cm_tag_o,
  output logic [LANES-1:0][AREG_W-1:0]   cm_areg_o,
  output logic [LANES-1:0]               gpr_we_o,
  output logic [LANES-1:0]               fpr_we_o,
  output logic [LANES-1:0]               cnt_we_o,
  output logic [LANES-1:0]               lnk_we_o,
  output logic [1:0]                     ret_n_o,
  output logic                           flush_o,
  output logic                           flush_at1_o,
  output logic                           redir_vld_o,
  output logic [ADDR_W-1:0]              redir_addr_o
);

  logic ok0, ok1, bad0, bad1;
  logic [CAUSE_W-1:0] sel_cause;

  assign ok0  = vld_i[0] & done_i[0] & ~exc_i[0];
  assign bad0 = vld_i[0] & done_i[0] &  exc_i[0];
  assign ok1  = ok0 & vld_i[1] & done_i[1] & ~exc_i[1];
  assign bad1 = ok0 & vld_i[1] & done_i[1] &  exc_i[1];

  assign flush_o     = bad0 | bad1;
  assign flush_at1_o = bad1;
  assign ret_n_o     = {ok1, ok0 & ~ok1};
  assign cm_vld_o    = {ok1, ok0};

  assign sel_cause    = bad0 ? cause_i[0] : cause_i[1];
  assign redir_vld_o  = flush_o;
  assign redir_addr_o = VEC_BASE + (ADDR_W'(sel_cause) << VEC_SHIFT);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign cm_tag_o[k]  = tag_i[k];
    assign cm_areg_o[k] = areg_i[k];
    assign gpr_we_o[k]  = cm_vld_o[k] & (dst_e'(dst_i[k]) == DST_GPR);
    assign fpr_we_o[k]  = cm_vld_o[k] & (dst_e'(dst_i[k]) == DST_FPR);
    assign cnt_we_o[k]  = cm_vld_o[k] & (dst_e'(dst_i[k]) == DST_CNT);
    assign lnk_we_o[k]  = cm_vld_o[k] & (dst_e'(dst_i[k]) == DST_LNK);
  end

endmodule

// File: rtl/cmpl_queue.sv
module cmpl_queue
  import rq_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned AREG_W    = 5,
  parameter int unsigned CAUSE_W   = 4,
  parameter int unsigned NFIN      = 2,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_0800,
  parameter int unsigned VEC_SHIFT = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [1:0]                       disp_vld_i,
  input  logic [1:0][TAG_W-1:0]            disp_tag_i,
  input  logic [1:0][1:0]                  disp_dst_i,
  input  logic [1:0][AREG_W-1:0]           disp_areg_i,
  output logic                             disp_stall_o,
  input  logic [NFIN-1:0]                  fin_vld_i,
  input  logic [NFIN-1:0][TAG_W-1:0]       fin_tag_i,
  input  logic [NFIN-1:0]                  fin_exc_i,
  input  logic [NFIN-1:0][CAUSE_W-1:0]     fin_cause_i,
  output logic [1:0]                       cm_vld_o,
  output logic [1:0][TAG_W-1:0]            cm_tag_o,
  output logic [1:0][AREG_W-1:0]           cm_areg_o,
  output logic [1:0]                       gpr_we_o,
  output logic [1:0]                       fpr_we_o,
  output logic [1:0]                       cnt_we_o,
  output logic [1:0]                       lnk_we_o,
  output logic                             redir_vld_o,
  output logic [ADDR_W-1:0]                redir_addr_o,
  output logic [DEPTH-1:0]                 fl_free_o,
  output logic [DEPTH-1:0][TAG_W-1:0]      fl_free_tag_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic                           rst_sync_n;
  logic [DEPTH-1:0]               q_vld;
  logic [DEPTH-1:0][TAG_W-1:0]    q_tag;
  logic [CNT_W-1:0]               q_cnt;
  logic [LANES-1:0]               b_done, b_exc;
  logic [LANES-1:0][CAUSE_W-1:0]  b_cause;
  logic [LANES-1:0][1:0]          b_dst;
  logic [LANES-1:0][AREG_W-1:0]   b_areg;
  logic [1:0]                     ret_n;
  logic                           flush, flush_at1;
  logic [CNT_W-1:0]               req_n, free_n;
  logic                           acc;

  rq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // dispatch admission: all requested lanes or none
  assign req_n        = CNT_W'(disp_vld_i[0]) + CNT_W'(disp_vld_i[1]);
  assign free_n       = CNT_W'(DEPTH) - q_cnt;
  assign disp_stall_o = flush | (req_n > free_n);
  assign acc          = (|disp_vld_i) & ~disp_stall_o;

  rq_slots #(
    .DEPTH   (DEPTH),
    .TAG_W   (TAG_W),
    .AREG_W  (AREG_W),
    .CAUSE_W (CAUSE_W),
    .NFIN    (NFIN)
  ) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .flush_i     (flush),
    .ret_n_i     (ret_n),
    .acc_i       (acc),
    .disp_vld_i  (disp_vld_i),
    .disp_tag_i  (disp_tag_i),
    .disp_dst_i  (disp_dst_i),
    .disp_areg_i (disp_areg_i),
    .fin_vld_i   (fin_vld_i),
    .fin_tag_i   (fin_tag_i),
    .fin_exc_i   (fin_exc_i),
    .fin_cause_i (fin_cause_i),
    .vld_o       (q_vld),
    .tag_o       (q_tag),
    .bot_done_o  (b_done),
    .bot_exc_o   (b_exc),
    .bot_cause_o (b_cause),
    .bot_dst_o   (b_dst),
    .bot_areg_o  (b_areg),
    .cnt_o       (q_cnt)
  );

  rq_retire #(
    .TAG_W     (TAG_W),
    .AREG_W    (AREG_W),
    .CAUSE_W   (CAUSE_W),
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_retire (
    .vld_i        (q_vld[1:0]),
    .done_i       (b_done),
    .exc_i        (b_exc),
    .cause_i      (b_cause),
    .tag_i        (q_tag[1:0]),
    .dst_i        (b_dst),
    .areg_i       (b_areg),
    .cm_vld_o     (cm_vld_o),
    .cm_tag_o     (cm_tag_o),
    .cm_areg_o    (cm_areg_o),
    .gpr_we_o     (gpr_we_o),
    .fpr_we_o     (fpr_we_o),
    .cnt_we_o     (cnt_we_o),
    .lnk_we_o     (lnk_we_o),
    .ret_n_o      (ret_n),
    .flush_o      (flush),
    .flush_at1_o  (flush_at1),
    .redir_vld_o  (redir_vld_o),
    .redir_addr_o (redir_addr_o)
  );

  // cancelled entries release their rename tags in the flush cycle
  for (genvar i = 0; i < DEPTH; i++) begin : g_free
    if (i == 0) begin : g_head
      assign fl_free_o[i] = flush & q_vld[i] & ~flush_at1;
    end else begin : g_rest
      assign fl_free_o[i] = flush & q_vld[i];
    end
    assign fl_free_tag_o[i] = q_tag[i];
  end

endmodule

// File: rtl/cmpl_queue_chk.sv
module cmpl_queue_chk #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       disp_vld_i,
  input logic             disp_stall_o,
  input logic [1:0]       cm_vld_o,
  input logic [1:0]       gpr_we_o,
  input logic [1:0]       fpr_we_o,
  input logic [1:0]       cnt_we_o,
  input logic [1:0]       lnk_we_o,
  input logic             redir_vld_o,
  input logic [DEPTH-1:0] fl_free_o,
  input logic [CNT_W-1:0] q_cnt
);

  assert_pair_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_vld_o[1] |-> cm_vld_o[0]);

  assert_exc_no_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |-> !cm_vld_o[1]);

  assert_empty_after_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |=> (q_cnt == '0));

  assert_free_only_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_free_o != '0) |-> redir_vld_o);

  assert_full_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_cnt == CNT_W'(DEPTH)) && (disp_vld_i != 2'b00)) |-> disp_stall_o);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= CNT_W'(DEPTH));

  assert_one_file_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gpr_we_o[0], fpr_we_o[0], cnt_we_o[0], lnk_we_o[0]}) &&
    $onehot0({gpr_we_o[1], fpr_we_o[1], cnt_we_o[1], lnk_we_o[1]}) &&
    (cm_vld_o[0] == |{gpr_we_o[0], fpr_we_o[0], cnt_we_o[0], lnk_we_o[0]}) &&
    (cm_vld_o[1] == |{gpr_we_o[1], fpr_we_o[1], cnt_we_o[1], lnk_we_o[1]}));

endmodule

bind cmpl_queue cmpl_queue_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_vld_i   (disp_vld_i),
  .disp_stall_o (disp_stall_o),
  .cm_vld_o     (cm_vld_o),
  .gpr_we_o     (gpr_we_o),
  .fpr_we_o     (fpr_we_o),
  .cnt_we_o     (cnt_we_o),
  .lnk_we_o     (lnk_we_o),
  .redir_vld_o  (redir_vld_o),
  .fl_free_o    (fl_free_o),
  .q_cnt        (q_cnt)
);

// File: tb/cmpl_queue_bench.sv
module cmpl_queue_bench;

  localparam int unsigned DEPTH = 6;
  localparam logic [31:0] VBASE = 32'h0000_0800;
  localparam int unsigned VSH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]       disp_vld;
  logic [1:0][3:0]  disp_tag;
  logic [1:0][1:0]  disp_dst;
  logic [1:0][4:0]  disp_areg;
  logic             disp_stall;
  logic [1:0]       fin_vld;
  logic [1:0][3:0]  fin_tag;
  logic [1:0]       fin_exc;
  logic [1:0][3:0]  fin_cause;
  logic [1:0]       cm_vld;
  logic [1:0][3:0]  cm_tag;
  logic [1:0][4:0]  cm_areg;
  logic [1:0]       gpr_we, fpr_we, cnt_we, lnk_we;
  logic             redir_vld;
  logic [31:0]      redir_addr;
  logic [5:0]       fl_free;
  logic [5:0][3:0]  fl_free_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmpl_queue #(
    .DEPTH (DEPTH), .TAG_W (4), .AREG_W (5), .CAUSE_W (4), .NFIN (2),
    .ADDR_W (32), .VEC_BASE (VBASE), .VEC_SHIFT (VSH)
  ) u_cmpl_queue (
    .clk_i (clk), .rst_ni (rst_n),
    .disp_vld_i (disp_vld), .disp_tag_i (disp_tag), .disp_dst_i (disp_dst),
    .disp_areg_i (disp_areg), .disp_stall_o (disp_stall),
    .fin_vld_i (fin_vld), .fin_tag_i (fin_tag), .fin_exc_i (fin_exc),
    .fin_cause_i (fin_cause),
    .cm_vld_o (cm_vld), .cm_tag_o (cm_tag), .cm_areg_o (cm_areg),
    .gpr_we_o (gpr_we), .fpr_we_o (fpr_we), .cnt_we_o (cnt_we), .lnk_we_o (lnk_we),
    .redir_vld_o (redir_vld), .redir_addr_o (redir_addr),
    .fl_free_o (fl_free), .fl_free_tag_o (fl_free_tag)
  );

  // one row: inputs of a cycle and the outputs expected before its clock edge
  typedef struct packed {
    logic [1:0] dn;
    logic [3:0] t0, t1;
    logic [1:0] fv;
    logic [3:0] ft0, ft1;
    logic       fx;
    logic [3:0] fc;
    logic       est;
    logic [1:0] ecm;
    logic [3:0] ec0, ec1;
    logic       erd;
    logic [3:0] ecs;
    logic [5:0] efr;
  } row_t;

  localparam int NROW = 15;
  localparam row_t ROWS [NROW] = '{
    '{2'd2, 4'd1,  4'd2,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd3,  4'd4,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd5,  4'd6,  2'd1, 4'd2,  4'd0,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd1, 4'd7,  4'd0,  2'd1, 4'd1,  4'd0,  1'b0, 4'd0, 1'b1, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd0, 4'd0,  4'd0,  2'd3, 4'd3,  4'd5,  1'b0, 4'd0, 1'b0, 2'b11, 4'd1,  4'd2, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd7,  4'd8,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b01, 4'd3,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd9,  4'd10, 2'd1, 4'd4,  4'd0,  1'b0, 4'd0, 1'b1, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd1, 4'd9,  4'd0,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b11, 4'd4,  4'd5, 1'b0, 4'd0, 6'b000000},
    '{2'd0, 4'd0,  4'd0,  2'd3, 4'd6,  4'd7,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd0, 4'd0,  4'd0,  2'd1, 4'd9,  4'd0,  1'b0, 4'd0, 1'b0, 2'b11, 4'd6,  4'd7, 1'b0, 4'd0, 6'b000000},
    '{2'd0, 4'd0,  4'd0,  2'd1, 4'd8,  4'd0,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd10, 4'd11, 2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b11, 4'd8,  4'd9, 1'b0, 4'd0, 6'b000000},
    '{2'd2, 4'd12, 4'd13, 2'd3, 4'd11, 4'd10, 1'b1, 4'd6, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000},
    '{2'd1, 4'd14, 4'd0,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b1, 2'b01, 4'd10, 4'd0, 1'b1, 4'd6, 6'b001110},
    '{2'd0, 4'd0,  4'd0,  2'd0, 4'd0,  4'd0,  1'b0, 4'd0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0, 4'd0, 6'b000000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // dispatched kind is tag[1:0] and register index is tag+3 throughout
  task automatic drive(input logic [1:0] dn, input logic [3:0] t0, input logic [3:0] t1,
                       input logic [1:0] fv, input logic [3:0] ft0, input logic [3:0] ft1,
                       input logic fx, input logic [3:0] fc);
    disp_vld     = (dn == 2'd2) ? 2'b11 : ((dn == 2'd1) ? 2'b01 : 2'b00);
    disp_tag[0]  = t0;
    disp_tag[1]  = t1;
    disp_dst[0]  = t0[1:0];
    disp_dst[1]  = t1[1:0];
    disp_areg[0] = 5'(t0) + 5'd3;
    disp_areg[1] = 5'(t1) + 5'd3;
    fin_vld      = fv;
    fin_tag[0]   = ft0;
    fin_tag[1]   = ft1;
    fin_exc      = {1'b0, fx};
    fin_cause[0] = fc;
    fin_cause[1] = 4'd0;
  endtask

  task automatic idle();
    drive(2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
  endtask

  task automatic chk_commit(input int k, input logic [3:0] tg);
    logic [3:0] we;
    we = {lnk_we[k], cnt_we[k], fpr_we[k], gpr_we[k]};
    chk("R4 commit tag", 64'(cm_tag[k]), 64'(tg));
    chk("R6 commit areg", 64'(cm_areg[k]), 64'(5'(tg) + 5'd3));
    chk("R6 write enable by kind", 64'(we), 64'(4'b0001 << tg[1:0]));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1: state held empty during reset
    drive(2'd2, 4'd1, 4'd2, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R1 no commit in reset", 64'(cm_vld), 64'd0);
    chk("R1 no redirect in reset", 64'(redir_vld), 64'd0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(2'd2, 4'd1, 4'd2, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R1 two-lane dispatch not stalled", 64'(disp_stall), 64'd0);
    chk("R1 no commit", 64'(cm_vld), 64'd0);
    chk("R1 no freed tags", 64'(fl_free), 64'd0);
    idle();

    // table-driven main walk
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      drive(ROWS[i].dn, ROWS[i].t0, ROWS[i].t1, ROWS[i].fv, ROWS[i].ft0, ROWS[i].ft1,
            ROWS[i].fx, ROWS[i].fc);
      #1;
      chk($sformatf("R2 stall row %0d", i), 64'(disp_stall), 64'(ROWS[i].est));
      chk($sformatf("R5 commit valid row %0d", i), 64'(cm_vld), 64'(ROWS[i].ecm));
      if (ROWS[i].ecm[0]) chk_commit(0, ROWS[i].ec0);
      if (ROWS[i].ecm[1]) chk_commit(1, ROWS[i].ec1);
      chk($sformatf("R7 redirect row %0d", i), 64'(redir_vld), 64'(ROWS[i].erd));
      chk($sformatf("R8 freed mask row %0d", i), 64'(fl_free), 64'(ROWS[i].efr));
      if (ROWS[i].erd)
        chk("R7 vector address", 64'(redir_addr), 64'(VBASE + (32'(ROWS[i].ecs) << VSH)));
    end

    // R7 R8: exception at the oldest of a full queue
    @(negedge clk); drive(2'd2, 4'd1, 4'd2, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    @(negedge clk); drive(2'd2, 4'd3, 4'd4, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    @(negedge clk); drive(2'd2, 4'd5, 4'd6, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    @(negedge clk); drive(2'd0, 4'd0, 4'd0, 2'd3, 4'd1, 4'd4, 1'b1, 4'd9);
    #1;
    chk("R9 no commit before finish lands", 64'(cm_vld), 64'd0);
    @(negedge clk); drive(2'd2, 4'd7, 4'd8, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R7 excepting oldest not committed", 64'(cm_vld), 64'd0);
    chk("R7 redirect raised", 64'(redir_vld), 64'd1);
    chk("R7 vector for cause 9", 64'(redir_addr), 64'(VBASE + (32'd9 << VSH)));
    chk("R8 all six tags freed", 64'(fl_free), 64'h3f);
    chk("R8 freed tag oldest", 64'(fl_free_tag[0]), 64'd1);
    chk("R8 freed tag youngest", 64'(fl_free_tag[5]), 64'd6);
    chk("R2 stall in flush cycle", 64'(disp_stall), 64'd1);
    // R3: stale finish for tag 4 after the flush has no effect
    @(negedge clk); drive(2'd2, 4'd7, 4'd8, 2'd1, 4'd4, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R8 queue empty after flush", 64'(disp_stall), 64'd0);
    chk("R8 no commit after flush", 64'(cm_vld), 64'd0);
    chk("R8 redirect one cycle", 64'(redir_vld), 64'd0);
    // R3 R5: younger finished alone waits
    @(negedge clk); drive(2'd0, 4'd0, 4'd0, 2'd3, 4'd8, 4'd2, 1'b0, 4'd0);
    #1;
    chk("R3 nothing finished yet", 64'(cm_vld), 64'd0);
    @(negedge clk); drive(2'd0, 4'd0, 4'd0, 2'd1, 4'd7, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R5 second waits for oldest", 64'(cm_vld), 64'd0);
    @(negedge clk); idle();
    #1;
    chk("R5 pair commits together", 64'(cm_vld), 64'd3);
    if (cm_vld[0]) chk_commit(0, 4'd7);
    if (cm_vld[1]) chk_commit(1, 4'd8);
    @(negedge clk); idle();
    #1;
    chk("R9 pair left the queue", 64'(cm_vld), 64'd0);

    // R1: reset in mid-run discards finished entries
    @(negedge clk); drive(2'd2, 4'd1, 4'd2, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    @(negedge clk); drive(2'd0, 4'd0, 4'd0, 2'd3, 4'd1, 4'd2, 1'b0, 4'd0);
    @(negedge clk); idle();
    #1;
    chk("R9 finished pair visible", 64'(cm_vld), 64'd3);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears commits", 64'(cm_vld), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(2'd2, 4'd3, 4'd4, 2'd0, 4'd0, 4'd0, 1'b0, 4'd0);
    #1;
    chk("R1 empty after reset", 64'(cm_vld), 64'd0);
    chk("R1 not stalled after reset", 64'(disp_stall), 64'd0);
    @(negedge clk); idle();

    finished = 1'b1;
    summary();
  end

endmodule